// File: doc/BRIEF.md
# Prescaled Periodic Down-Counter Timer

A bank of identical down-counting timers behind one small register window. Each timer keeps a reload value and a live count, and a control byte that starts it, picks periodic or one-shot behaviour, gates its interrupt and selects how many clock-enable ticks make one count step. When the count is stepped while already at zero, the timer either reloads from its reload value (periodic) or parks at zero and switches itself off (one-shot), and in both cases raises a sticky expiry flag. Software finds the time since the last expiry as the reload value minus the live count, and acknowledges the interrupt by writing anything to the timer's acknowledge register.

The register port is a plain single-cycle write strobe with a word address and a combinational read path. Every write is taken in the cycle its strobe is high, so there is no back-pressure and no handshake to wait on. The `tick_en` input is a clock enable from elsewhere in the chip; it carries no data.

Top module: `prescaled_down_timer`

## Requirements
- R1: Each timer occupies a 0x20-byte slot; the slot is chosen by byte address bit 5 (word address bit 3) and, within a slot, byte offset 0x00 is the reload value, 0x04 the live count, 0x08 the control byte (bits 31:8 read 0) and 0x0C the acknowledge register, which reads 0. After reset every register reads 0 and every interrupt is low.
- R2: Writing the reload register stores the value and loads the live count with it in the same cycle, taking priority over a count step in that cycle.
- R3: The count decrements by one on each step; steps happen only while control bit 7 is 1, and come every tick (code 00 in control bits 3:2), every 16th tick (01) or every 256th tick (10 and 11).
- R4: With control bit 6 set, a step taken at count zero reloads the reload value and sets the expiry flag, so the period is reload+1 steps.
- R5: With control bit 6 clear, a step taken at count zero leaves the count at zero, sets the expiry flag and clears control bit 7.
- R6: A timer's interrupt output is its expiry flag gated by control bit 5; the flag itself is unaffected by bit 5.
- R7: Any write to the acknowledge register clears the expiry flag, except when an expiry happens in the same cycle, in which case the flag stays set.
- R8: Writing 0 to control freezes the count; while control bit 7 is 0 the prescaler is held at its start, so the first step after re-enabling comes a full division period later.
- R9: Writes to the live-count offset and to the unused offsets 0x10 to 0x1C change no register.
- R10: Timers are independent: accesses to one slot never change another slot's registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count clock enable, one tick per high cycle |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | ADDR_W-2 (4) | Word address, byte address bits 5:2 |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Read data for bus_addr, combinational |
| irq | output | NUM_TIMERS (2) | Per-timer interrupt |

## Verification
The counting function is driven from a table of reload values, control bytes and wait lengths that covers all four prescale codes, both timer slots, waits that stop short of expiry and waits that land exactly on a wrap, so that an off-by-one in the period, a wrong division ratio or a missing code-11 alias each shows up as a different count. Directed cases then set an acknowledge write on the same edge as an expiry, reload while running, stop and restart the prescaler mid-period, run one-shot past zero and write the read-only and unused offsets, each of which separates a priority or hold rule from its plausible alternative.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  localparam int CTRL_W    = 8;
  localparam int BIT_RUN   = 7;
  localparam int BIT_AUTO  = 6;
  localparam int BIT_IRQEN = 5;
  localparam int PS_LO     = 2;
  localparam int SHIFT_MID = 4;
  localparam int SHIFT_HI  = 8;
  localparam int SLOT_W    = 5;

  localparam logic [2:0] SEL_RELOAD = 3'd0;
  localparam logic [2:0] SEL_COUNT  = 3'd1;
  localparam logic [2:0] SEL_CTRL   = 3'd2;
  localparam logic [2:0] SEL_ACK    = 3'd3;

  typedef enum logic [1:0] {
    PS_ONE     = 2'b00,
    PS_SIXTEEN = 2'b01,
    PS_MAX     = 2'b10,
    PS_MAX_ALT = 2'b11
  } ps_code_e;
endpackage

// File: rtl/dtt_prescaler.sv
module dtt_prescaler
  import dtt_pkg::*;
#(
  parameter int PRE_W = SHIFT_HI
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick_en,
  input  logic [1:0] ps_code,
  output logic       step
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] term;

  always_comb begin
    case (ps_code_e'(ps_code))
      PS_ONE:     term = '0;
      PS_SIXTEEN: term = PRE_W'((1 << SHIFT_MID) - 1);
      default:    term = PRE_W'((1 << SHIFT_HI) - 1);
    endcase
  end

  assign step = run && tick_en && (pre_q == term);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pre_q <= '0;
    end else if (tick_en) begin
      pre_q <= (pre_q == term) ? '0 : pre_q + 1'b1;
    end
  end

  assert_step_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ps_code != 2'b00) |=> (!step || ps_code == 2'b00));
endmodule

// File: rtl/dtt_core.sv
module dtt_core
  import dtt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_load,
  input  logic              wr_ctrl,
  input  logic              wr_ack,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  reload_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              irq_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  reload_q;
  logic [CNT_W-1:0]  count_q;
  logic              flag_q;
  logic              step;
  logic              expire;
  logic              periodic;

  assign periodic = ctrl_q[BIT_AUTO];

  dtt_prescaler #(.PRE_W(SHIFT_HI)) pre_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q[BIT_RUN]),
    .tick_en (tick_en),
    .ps_code (ctrl_q[PS_LO+1:PS_LO]),
    .step    (step)
  );

  assign expire = step && (count_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= wdata[CTRL_W-1:0];
    end else if (expire && !periodic) begin
      ctrl_q[BIT_RUN] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_load) reload_q <= wdata;
      if (wr_load) begin
        count_q <= wdata;
      end else if (step) begin
        if (count_q == '0) count_q <= periodic ? reload_q : '0;
        else               count_q <= count_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (expire) flag_q <= 1'b1;
    else if (wr_ack) flag_q <= 1'b0;
  end

  assign reload_o = reload_q;
  assign count_o  = count_q;
  assign ctrl_o   = ctrl_q;
  assign irq_o    = flag_q && ctrl_q[BIT_IRQEN];

  assert_load_copies_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> (count_q == $past(wdata) && reload_q == $past(wdata)));
  assert_count_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= reload_q);
  assert_frozen_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[BIT_RUN] && !wr_load) |=> $stable(count_q));
  assert_oneshot_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !periodic && !wr_ctrl) |=> (!ctrl_q[BIT_RUN] && flag_q && count_q == '0));
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && !expire) |=> !flag_q);
  assert_expiry_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag_q);
endmodule

// File: rtl/prescaled_down_timer.sv
module prescaled_down_timer
  import dtt_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int CNT_W      = 32,
  localparam int INST_W    = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1,
  localparam int ADDR_W    = SLOT_W + INST_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_en,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:2]     bus_addr,
  input  logic [CNT_W-1:0]      bus_wdata,
  output logic [CNT_W-1:0]      bus_rdata,
  output logic [NUM_TIMERS-1:0] irq
);
  logic [INST_W-1:0] inst_sel;
  logic [2:0]        reg_sel;

  assign inst_sel = bus_addr[ADDR_W-1:SLOT_W];
  assign reg_sel  = bus_addr[SLOT_W-1:2];

  logic [CNT_W-1:0]  reload_a [NUM_TIMERS];
  logic [CNT_W-1:0]  count_a  [NUM_TIMERS];
  logic [CTRL_W-1:0] ctrl_a   [NUM_TIMERS];

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
    logic hit;
    assign hit = bus_wr && (inst_sel == INST_W'(i));

    dtt_core #(.CNT_W(CNT_W)) core_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .wr_load  (hit && reg_sel == SEL_RELOAD),
      .wr_ctrl  (hit && reg_sel == SEL_CTRL),
      .wr_ack   (hit && reg_sel == SEL_ACK),
      .wdata    (bus_wdata),
      .reload_o (reload_a[i]),
      .count_o  (count_a[i]),
      .ctrl_o   (ctrl_a[i]),
      .irq_o    (irq[i])
    );

    assert_count_readonly_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && reg_sel == SEL_COUNT && !ctrl_a[i][BIT_RUN]) |=> $stable(count_a[i]));
    assert_other_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && inst_sel != INST_W'(i)) |=> ($stable(reload_a[i])));
  end

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NUM_TIMERS; k++) begin
      if (inst_sel == INST_W'(k)) begin
        case (reg_sel)
          SEL_RELOAD: bus_rdata = reload_a[k];
          SEL_COUNT:  bus_rdata = count_a[k];
          SEL_CTRL:   bus_rdata = CNT_W'(ctrl_a[k]);
          default:    bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: tb/prescaled_down_timer_tb.sv
`timescale 1ns/1ps
module prescaled_down_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b1;
  logic        bus_wr = 1'b0;
  logic [5:2]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  prescaled_down_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct packed {
    logic [5:0]  base;
    logic [31:0] ld;
    logic [7:0]  cr;
    logic [15:0] n;
    logic [31:0] cnt;
    logic        irq;
  } vec_t;

  // expected count = ld - (floor(n/div) mod (ld+1)); irq when floor(n/div) > ld and bit5 set
  localparam vec_t VECS [7] = '{
    '{6'h00, 32'd10, 8'hE0, 16'd5,   32'd5, 1'b0},
    '{6'h00, 32'd10, 8'hE0, 16'd11,  32'd10, 1'b1},
    '{6'h20, 32'd3,  8'hE4, 16'd40,  32'd1, 1'b0},
    '{6'h20, 32'd3,  8'hE4, 16'd64,  32'd3, 1'b1},
    '{6'h00, 32'd2,  8'hC8, 16'd768, 32'd2, 1'b0},
    '{6'h20, 32'd5,  8'hCC, 16'd600, 32'd3, 1'b0},
    '{6'h00, 32'd7,  8'hE0, 16'd3,   32'd4, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_addr = a[5:2]; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a[5:2];
    #1;
    d = bus_rdata;
  endtask

  task automatic start(input logic [5:0] b, input logic [31:0] ld, input logic [7:0] cr);
    wr(b + 6'h08, 32'h0);
    wr(b + 6'h0C, 32'h0);
    wr(b, ld);
    wr(b + 6'h08, {24'h0, cr});
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d, held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and map
    rd(6'h00, d); chk("R1 reset reload", d, 0);
    rd(6'h04, d); chk("R1 reset count", d, 0);
    rd(6'h28, d); chk("R1 reset ctrl slot1", d, 0);
    chk("R1 reset irq", {30'h0, irq}, 0);

    // R3 R4 R6 table of counting vectors
    for (int k = 0; k < 7; k++) begin
      start(VECS[k].base, VECS[k].ld, VECS[k].cr);
      repeat (int'(VECS[k].n)) @(negedge clk);
      rd(VECS[k].base + 6'h04, d);
      chk($sformatf("R3/R4 vector %0d count", k), d, VECS[k].cnt);
      chk($sformatf("R6 vector %0d irq", k), {31'h0, irq[VECS[k].base[5]]}, {31'h0, VECS[k].irq});
    end

    // R6: flag raised while masked appears once bit5 set (timer0 from vector 4 already expired, then restarted)
    start(6'h00, 32'd2, 8'hC0);
    repeat (4) @(negedge clk);
    chk("R6 masked irq", {31'h0, irq[0]}, 0);
    wr(6'h08, 32'hE0);
    chk("R6 unmasked irq", {31'h0, irq[0]}, 1);

    // R10 park timer1
    start(6'h20, 32'h33, 8'h00);

    // R7 ack clears
    start(6'h00, 32'd4, 8'hE0);
    repeat (5) @(negedge clk);
    chk("R7 irq before ack", {31'h0, irq[0]}, 1);
    wr(6'h0C, 32'h1234);
    chk("R7 irq after ack", {31'h0, irq[0]}, 0);
    rd(6'h0C, d); chk("R1 ack reads zero", d, 0);

    // R7 expiry on the same edge as ack wins
    start(6'h00, 32'd4, 8'hE0);
    repeat (4) @(negedge clk);
    wr(6'h0C, 32'h0);
    chk("R7 expiry beats ack", {31'h0, irq[0]}, 1);

    // R2 reload while running
    start(6'h00, 32'd10, 8'hC0);
    repeat (3) @(negedge clk);
    wr(6'h00, 32'd50);
    rd(6'h04, d); chk("R2 immediate load", d, 50);

    // R8 stop freezes
    start(6'h00, 32'd20, 8'hC0);
    repeat (5) @(negedge clk);
    wr(6'h08, 32'h0);
    rd(6'h04, held); chk("R8 count at stop", held, 14);
    repeat (10) @(negedge clk);
    rd(6'h04, d); chk("R8 frozen count", d, held);

    // R8 prescaler restarts
    start(6'h00, 32'd100, 8'hC4);
    repeat (8) @(negedge clk);
    wr(6'h08, 32'h44);
    wr(6'h08, 32'hC4);
    repeat (15) @(negedge clk);
    rd(6'h04, d); chk("R8 no early step", d, 100);
    @(negedge clk);
    rd(6'h04, d); chk("R8 step after full period", d, 99);

    // R5 one-shot
    start(6'h00, 32'd2, 8'hA0);
    repeat (6) @(negedge clk);
    rd(6'h04, d); chk("R5 parked count", d, 0);
    chk("R5 irq", {31'h0, irq[0]}, 1);
    rd(6'h08, d); chk("R5 run bit cleared", d, 32'h20);

    // R9 read-only and unused offsets
    start(6'h00, 32'd9, 8'h00);
    wr(6'h04, 32'h55);
    wr(6'h10, 32'hFF);
    wr(6'h1C, 32'hFF);
    rd(6'h04, d); chk("R9 count unchanged", d, 9);
    rd(6'h00, d); chk("R9 reload unchanged", d, 9);
    rd(6'h08, d); chk("R9 ctrl unchanged", d, 0);
    rd(6'h10, d); chk("R9 unused reads zero", d, 0);

    // R10 timer1 untouched by timer0 traffic
    rd(6'h24, d); chk("R10 other count", d, 32'h33);
    rd(6'h20, d); chk("R10 other reload", d, 32'h33);

    summary();
  end
endmodule